// File: doc/BRIEF.md
# Smart-Card Session Controller

This block is the top-level sequencer for a contact smart-card port. Software issues one-cycle action requests (power on, power off, warm reset, receive, transmit, transmit-then-receive, clock stop). The block moves the card through its power and transfer states. It drives the card supply enable, the active-low card reset and the card clock. It also reports a busy flag, a state code and one-cycle interrupt pulses.

The character framing datapath and the memory mover are outside this block. They report back through plain event pins: answer-to-reset start, transfer completions and error events. The block runs the timed activation sequence with a fixed reset hold. It then watches for the answer to reset against a programmable timeout. It also runs the clock-stop, clock-resume and deactivation sequences, each with fixed gaps counted in card clock periods.

There is no data stream at this boundary. Every pin is a plain control or status signal, and no back-pressure applies. An action is taken in the cycle `act_valid` is high. The card clock period is 2*(`clk_div`+1) system clocks.

Top module: `sc_session_ctrl`

## Requirements
- R1: After reset, `sess_state` is 0 (OFF), and `card_vcc_en`, `card_rst_n`, `card_clk`, `busy` and every interrupt are 0.
- R2: `sess_state` codes are 0 OFF, 1 reset hold, 2 awaiting answer to reset, 3 IDLE, 4 RX, 5 TX, 6 TX_RX, 7 clock stopping, 8 STOP, 9 clock resuming, 10 deactivating (reset low), 11 deactivating (clock stopped). `busy` is 0 exactly in OFF, IDLE and STOP.
- R3: Action codes are 0 NONE, 1 ON, 2 OFF, 3 WARM, 4 RX, 5 TX, 6 TX_RX, 7 STOP. NONE has no effect. An action not allowed in the current state gives one `irq_state_err` pulse and leaves the state and the sequence in progress unchanged. Allowed actions are: ON from OFF; ON, OFF, WARM, RX, TX, TX_RX and STOP from IDLE; ON from STOP. Every action is illegal in any other state.
- R4: `irq_done` pulses when OFF, IDLE or STOP is entered by normal completion. It never pulses together with an error interrupt, and it never pulses while `busy` is 1.
- R5: ON from OFF raises `card_vcc_en` and starts the card clock with `card_rst_n` low. `card_rst_n` rises after exactly RST_HOLD (400) rising card clock edges.
- R6: After reset release, `atr_start` moves the state to RX. If `atr_start` has not arrived after (`etu_div`+1)*`wait_etu` rising card clock edges, `irq_rx_err` pulses and the state becomes IDLE.
- R7: ON while in IDLE only pulses `irq_done`. The state and all pins stay unchanged.
- R8: WARM from IDLE keeps `card_vcc_en` high, drives `card_rst_n` low and then follows the R5 hold and the R6 answer wait.
- R9: In RX, TX or TX_RX, each asserted error input (`rx_err`, `retry_err`, `dma_err`) pulses its own interrupt, and the state becomes IDLE with no `irq_done`.
- R10: `rx_done` ends RX and `tx_done` ends TX, each going to IDLE with `irq_done`. In TX_RX, `tx_done` moves to RX without `irq_done`.
- R11: STOP from IDLE waits STOP_GAP card periods and then enters STOP. In STOP, `card_clk` follows `stop_level`. ON from STOP waits STOP_GAP periods with the clock running and then returns to IDLE.
- R12: Completion and error inputs have no effect outside RX, TX and TX_RX.
- R13: OFF from IDLE first drives `card_rst_n` low with the clock running. After OFF_GAP periods it stops the clock low. After OFF_GAP more periods it drops `card_vcc_en` and enters OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_valid | input | 1 | Action request strobe |
| act_code | input | 3 | Requested action (R3 encoding) |
| clk_div | input | DIV_W | Card clock half-period minus one, in system clocks |
| etu_div | input | ETU_W | Card clocks per ETU minus one |
| wait_etu | input | WAIT_W | Answer-to-reset timeout in ETU |
| stop_level | input | 1 | Card clock level while stopped |
| atr_start | input | 1 | Datapath saw the first answer-to-reset start bit |
| tx_done | input | 1 | Transmit phase complete |
| rx_done | input | 1 | Receive phase complete |
| rx_err | input | 1 | Receive error event |
| retry_err | input | 1 | Retry limit event |
| dma_err | input | 1 | Memory mover error event |
| card_vcc_en | output | 1 | Card supply enable |
| card_rst_n | output | 1 | Card reset, active low |
| card_clk | output | 1 | Card clock |
| busy | output | 1 | Active-state flag |
| sess_state | output | 4 | State code (R2) |
| irq_done | output | 1 | Done pulse |
| irq_state_err | output | 1 | Illegal-action pulse |
| irq_rx_err | output | 1 | Receive error pulse |
| irq_retry_err | output | 1 | Retry error pulse |
| irq_dma_err | output | 1 | Memory error pulse |

## Verification
The hardest situation to reach is an exact edge count across a sequence boundary. A warm reset starts while the card clock is already toggling, so an edge can land in the same cycle that reset drops. The timeout count also starts on the very cycle reset rises. The bench counts card clock rises only while reset has been low on two consecutive samples, and separately after release. It checks both counts against R5 and R6, with a short ETU and wait setting so the timeout falls within a few dozen edges. Illegal requests are injected in the middle of the hold and at random points of randomized transfers, so they land while an operation is in flight.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [3:0] {
    ST_OFF        = 4'd0,
    ST_ACT_HOLD   = 4'd1,
    ST_ACT_ATR    = 4'd2,
    ST_IDLE       = 4'd3,
    ST_RX         = 4'd4,
    ST_TX         = 4'd5,
    ST_TXRX       = 4'd6,
    ST_STOP_ENTER = 4'd7,
    ST_STOP       = 4'd8,
    ST_STOP_LEAVE = 4'd9,
    ST_DEACT_RST  = 4'd10,
    ST_DEACT_CLK  = 4'd11
  } sess_state_e;

  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_ON   = 3'd1,
    ACT_OFF  = 3'd2,
    ACT_WARM = 3'd3,
    ACT_RX   = 3'd4,
    ACT_TX   = 3'd5,
    ACT_TXRX = 3'd6,
    ACT_STOP = 3'd7
  } action_e;

endpackage

// File: rtl/sc_clkgen.sv
module sc_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             phase,
  output logic             phase_rise
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      phase      <= 1'b0;
      phase_rise <= 1'b0;
    end else begin
      phase_rise <= 1'b0;
      if (wrap) begin
        cnt        <= '0;
        phase      <= ~phase;
        phase_rise <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sc_step_count.sv
module sc_step_count #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clr)
      count <= '0;
    else if (inc && (count != {W{1'b1}}))
      count <= count + 1'b1;
  end

endmodule

// File: rtl/sc_atr_timer.sv
module sc_atr_timer #(
  parameter int ETU_W  = 10,
  parameter int WAIT_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [ETU_W-1:0]  etu_div,
  input  logic [WAIT_W-1:0] wait_etu,
  output logic              expired
);

  logic [ETU_W-1:0]  etu_cnt;
  logic [WAIT_W-1:0] etu_seen;

  assign expired = (etu_seen >= wait_etu);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      etu_cnt  <= '0;
      etu_seen <= '0;
    end else if (clr) begin
      etu_cnt  <= '0;
      etu_seen <= '0;
    end else if (inc && !expired) begin
      if (etu_cnt >= etu_div) begin
        etu_cnt  <= '0;
        etu_seen <= etu_seen + 1'b1;
      end else begin
        etu_cnt <= etu_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sc_session_ctrl.sv
module sc_session_ctrl
  import sc_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int ETU_W    = 10,
  parameter int WAIT_W   = 18,
  parameter int RST_HOLD = 400,
  parameter int STOP_GAP = 8,
  parameter int OFF_GAP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [2:0]        act_code,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [ETU_W-1:0]  etu_div,
  input  logic [WAIT_W-1:0] wait_etu,
  input  logic              stop_level,
  input  logic              atr_start,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic              rx_err,
  input  logic              retry_err,
  input  logic              dma_err,
  output logic              card_vcc_en,
  output logic              card_rst_n,
  output logic              card_clk,
  output logic              busy,
  output logic [3:0]        sess_state,
  output logic              irq_done,
  output logic              irq_state_err,
  output logic              irq_rx_err,
  output logic              irq_retry_err,
  output logic              irq_dma_err
);

  localparam int GAP_MAX  = (STOP_GAP > OFF_GAP) ? STOP_GAP : OFF_GAP;
  localparam int STEP_MAX = (RST_HOLD > GAP_MAX) ? RST_HOLD : GAP_MAX;
  localparam int CNT_W    = $clog2(STEP_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(RST_HOLD);
  localparam logic [CNT_W-1:0] STOP_END = CNT_W'(STOP_GAP);
  localparam logic [CNT_W-1:0] OFF_END  = CNT_W'(OFF_GAP);

  sess_state_e state, state_nxt;
  logic rst_q, rst_nxt, vcc_q, vcc_nxt, clk_q, clk_nxt;
  logic done_set, serr_set, rxe_set, rte_set, dme_set;
  logic phase, phase_rise, out_rise, clk_run, step_inc, atr_expired, act_req;
  logic [CNT_W-1:0] step_cnt;
  action_e act;

  sc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .div(clk_div),
    .phase(phase), .phase_rise(phase_rise)
  );

  // Card clock: runs in every powered state except STOP and the last deactivation step.
  always_comb begin
    clk_run = 1'b1;
    unique case (state)
      ST_OFF, ST_STOP, ST_DEACT_CLK: clk_run = 1'b0;
      default:                       clk_run = 1'b1;
    endcase
    if (clk_run)               clk_nxt = phase;
    else if (state == ST_STOP) clk_nxt = stop_level;
    else                       clk_nxt = 1'b0;
  end

  assign out_rise = clk_nxt & ~clk_q;
  // The reset hold counts edges seen on the pin; the other gaps count divider periods.
  assign step_inc = (state == ST_ACT_HOLD) ? out_rise : phase_rise;

  sc_step_count #(.W(CNT_W)) u_step (
    .clk(clk), .rst_n(rst_n), .clr(state_nxt != state),
    .inc(step_inc), .count(step_cnt)
  );

  sc_atr_timer #(.ETU_W(ETU_W), .WAIT_W(WAIT_W)) u_atr (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_ACT_ATR), .inc(out_rise),
    .etu_div(etu_div), .wait_etu(wait_etu), .expired(atr_expired)
  );

  assign act     = action_e'(act_code);
  assign act_req = act_valid && (act != ACT_NONE);

  always_comb begin
    state_nxt = state;
    rst_nxt   = rst_q;
    vcc_nxt   = vcc_q;
    done_set  = 1'b0;
    serr_set  = 1'b0;
    rxe_set   = 1'b0;
    rte_set   = 1'b0;
    dme_set   = 1'b0;
    unique case (state)
      ST_OFF: begin
        if (act_req) begin
          if (act == ACT_ON) begin
            state_nxt = ST_ACT_HOLD;
            vcc_nxt   = 1'b1;
            rst_nxt   = 1'b0;
          end else begin
            serr_set = 1'b1;
          end
        end
      end
      ST_ACT_HOLD: begin
        serr_set = act_req;
        if (step_cnt == HOLD_END) begin
          rst_nxt   = 1'b1;
          state_nxt = ST_ACT_ATR;
        end
      end
      ST_ACT_ATR: begin
        serr_set = act_req;
        if (atr_start) begin
          state_nxt = ST_RX;
        end else if (atr_expired) begin
          rxe_set   = 1'b1;
          state_nxt = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (act_req) begin
          unique case (act)
            ACT_ON:   done_set = 1'b1;
            ACT_OFF: begin
              state_nxt = ST_DEACT_RST;
              rst_nxt   = 1'b0;
            end
            ACT_WARM: begin
              state_nxt = ST_ACT_HOLD;
              rst_nxt   = 1'b0;
            end
            ACT_RX:   state_nxt = ST_RX;
            ACT_TX:   state_nxt = ST_TX;
            ACT_TXRX: state_nxt = ST_TXRX;
            ACT_STOP: state_nxt = ST_STOP_ENTER;
            default:  state_nxt = ST_IDLE;
          endcase
        end
      end
      ST_RX, ST_TX, ST_TXRX: begin
        serr_set = act_req;
        rxe_set  = rx_err;
        rte_set  = retry_err;
        dme_set  = dma_err;
        if (rx_err || retry_err || dma_err) begin
          state_nxt = ST_IDLE;
        end else if ((state == ST_RX) && rx_done) begin
          state_nxt = ST_IDLE;
          done_set  = 1'b1;
        end else if ((state == ST_TX) && tx_done) begin
          state_nxt = ST_IDLE;
          done_set  = 1'b1;
        end else if ((state == ST_TXRX) && tx_done) begin
          state_nxt = ST_RX;
        end
      end
      ST_STOP_ENTER: begin
        serr_set = act_req;
        if (step_cnt == STOP_END) begin
          state_nxt = ST_STOP;
          done_set  = 1'b1;
        end
      end
      ST_STOP: begin
        if (act_req) begin
          if (act == ACT_ON) state_nxt = ST_STOP_LEAVE;
          else               serr_set  = 1'b1;
        end
      end
      ST_STOP_LEAVE: begin
        serr_set = act_req;
        if (step_cnt == STOP_END) begin
          state_nxt = ST_IDLE;
          done_set  = 1'b1;
        end
      end
      ST_DEACT_RST: begin
        serr_set = act_req;
        if (step_cnt == OFF_END) state_nxt = ST_DEACT_CLK;
      end
      ST_DEACT_CLK: begin
        serr_set = act_req;
        if (step_cnt == OFF_END) begin
          state_nxt = ST_OFF;
          vcc_nxt   = 1'b0;
          done_set  = 1'b1;
        end
      end
      default: state_nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_OFF;
      rst_q         <= 1'b0;
      vcc_q         <= 1'b0;
      clk_q         <= 1'b0;
      irq_done      <= 1'b0;
      irq_state_err <= 1'b0;
      irq_rx_err    <= 1'b0;
      irq_retry_err <= 1'b0;
      irq_dma_err   <= 1'b0;
    end else begin
      state         <= state_nxt;
      rst_q         <= rst_nxt;
      vcc_q         <= vcc_nxt;
      clk_q         <= clk_nxt;
      irq_done      <= done_set;
      irq_state_err <= serr_set;
      irq_rx_err    <= rxe_set;
      irq_retry_err <= rte_set;
      irq_dma_err   <= dme_set;
    end
  end

  assign card_vcc_en = vcc_q;
  assign card_rst_n  = rst_q;
  assign card_clk    = clk_q;
  assign sess_state  = state;
  assign busy        = !((state == ST_OFF) || (state == ST_IDLE) || (state == ST_STOP));

endmodule

// File: rtl/sc_session_chk.sv
module sc_session_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] sess_state,
  input logic       busy,
  input logic       card_vcc_en,
  input logic       card_rst_n,
  input logic       card_clk,
  input logic       stop_level,
  input logic       irq_done,
  input logic       irq_rx_err,
  input logic       irq_retry_err,
  input logic       irq_dma_err
);

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_state == 4'd0) |-> (!card_vcc_en && !card_rst_n && !card_clk));

  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !busy);

  assert_done_no_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !(irq_rx_err || irq_retry_err || irq_dma_err));

  assert_hold_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_state == 4'd1) |-> (!card_rst_n && card_vcc_en));

  assert_error_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx_err || irq_retry_err || irq_dma_err) |-> (sess_state == 4'd3));

  assert_stop_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sess_state == 4'd8) && ($past(sess_state) == 4'd8)) |-> (card_clk == $past(stop_level)));

  assert_deact_order_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_state == 4'd11) |-> (!card_rst_n && card_vcc_en));

endmodule

bind sc_session_ctrl sc_session_chk u_sc_session_chk (
  .clk(clk), .rst_n(rst_n), .sess_state(sess_state), .busy(busy),
  .card_vcc_en(card_vcc_en), .card_rst_n(card_rst_n), .card_clk(card_clk),
  .stop_level(stop_level), .irq_done(irq_done), .irq_rx_err(irq_rx_err),
  .irq_retry_err(irq_retry_err), .irq_dma_err(irq_dma_err)
);

// File: tb/test_sc_session_ctrl.sv
`timescale 1ns/1ps
module test_sc_session_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_valid = 1'b0;
  logic [2:0] act_code = 3'd0;
  logic [7:0] clk_div = 8'd1;
  logic [9:0] etu_div = 10'd3;
  logic [17:0] wait_etu = 18'd5;
  logic stop_level = 1'b0;
  logic atr_start = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
  logic rx_err = 1'b0, retry_err = 1'b0, dma_err = 1'b0;
  logic card_vcc_en, card_rst_n, card_clk, busy;
  logic [3:0] sess_state;
  logic irq_done, irq_state_err, irq_rx_err, irq_retry_err, irq_dma_err;

  always #2.5 clk = ~clk;

  sc_session_ctrl i_sc_session_ctrl (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_code(act_code),
    .clk_div(clk_div), .etu_div(etu_div), .wait_etu(wait_etu),
    .stop_level(stop_level), .atr_start(atr_start), .tx_done(tx_done),
    .rx_done(rx_done), .rx_err(rx_err), .retry_err(retry_err), .dma_err(dma_err),
    .card_vcc_en(card_vcc_en), .card_rst_n(card_rst_n), .card_clk(card_clk),
    .busy(busy), .sess_state(sess_state), .irq_done(irq_done),
    .irq_state_err(irq_state_err), .irq_rx_err(irq_rx_err),
    .irq_retry_err(irq_retry_err), .irq_dma_err(irq_dma_err)
  );

  // Pulse and edge monitors, sampled away from the active edge.
  int n_done = 0, n_serr = 0, n_rxe = 0, n_rte = 0, n_dme = 0;
  int hold_rises = 0, post_rises = 0;
  logic prev_clk = 1'b0, prev_rst = 1'b0;
  always @(negedge clk) begin
    if (irq_done)      n_done++;
    if (irq_state_err) n_serr++;
    if (irq_rx_err)    n_rxe++;
    if (irq_retry_err) n_rte++;
    if (irq_dma_err)   n_dme++;
    if (card_clk && !prev_clk) begin
      if (!card_rst_n && !prev_rst) hold_rises++;
      if (card_rst_n)               post_rises++;
    end
    prev_clk = card_clk;
    prev_rst = card_rst_n;
  end

  int nchk = 0, nerr = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int atr_limit(input int e, input int w);
    return (e + 1) * w;
  endfunction

  // State reached after a transfer of code op ends with kind k (0 done, 1..3 errors).
  function automatic int exp_end_state(input int op, input int k);
    if (k != 0) return 3;
    return 3;
  endfunction

  function automatic int exp_busy(input int st);
    return (st == 0 || st == 3 || st == 8) ? 0 : 1;
  endfunction

  task automatic do_act(input int code);
    @(negedge clk);
    act_code  = 3'(code);
    act_valid = 1'b1;
    @(negedge clk);
    act_valid = 1'b0;
    act_code  = 3'd0;
    #1;
  endtask

  task automatic pulse_ev(input int which);
    @(negedge clk);
    case (which)
      0: atr_start = 1'b1;
      1: tx_done   = 1'b1;
      2: rx_done   = 1'b1;
      3: rx_err    = 1'b1;
      4: retry_err = 1'b1;
      default: dma_err = 1'b1;
    endcase
    @(negedge clk);
    {atr_start, tx_done, rx_done, rx_err, retry_err, dma_err} = 6'd0;
    #1;
  endtask

  task automatic wait_state(input int s);
    while (int'(sess_state) != s) @(negedge clk);
    #1;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic run_all();
    int b_done, b_serr, b_rxe, b_rte, b_dme, b_hold, b_post;
    void'($urandom(32'd20240611));
    idle_cycles(4);
    rst_n = 1'b1;
    idle_cycles(2);
    // R1 reset state
    chk("R1 state", sess_state, 0);
    chk("R1 pins", {card_vcc_en, card_rst_n, card_clk, busy}, 0);

    // R3 NONE and illegal action in OFF
    b_serr = n_serr;
    do_act(0);
    chk("R3 none state", sess_state, 0);
    chk("R3 none serr", n_serr - b_serr, 0);
    do_act(4);
    chk("R3 illegal in OFF serr", n_serr - b_serr, 1);
    chk("R3 illegal in OFF state", sess_state, 0);

    // R5 cold activation, R3 illegal during hold, R6 timeout
    b_hold = hold_rises;
    do_act(1);
    chk("R5 hold state", sess_state, 1);
    chk("R5 vcc/rst", {card_vcc_en, card_rst_n}, 2);
    chk("R2 busy in hold", busy, exp_busy(1));
    b_serr = n_serr;
    idle_cycles(37);
    do_act(5);
    chk("R3 illegal in hold serr", n_serr - b_serr, 1);
    chk("R3 hold continues", sess_state, 1);
    wait_state(2);
    chk("R5 hold edges", hold_rises - b_hold, 400);
    b_post = post_rises; b_rxe = n_rxe; b_done = n_done;
    wait_state(3);
    chk("R6 timeout edges", post_rises - b_post, atr_limit(3, 5));
    chk("R6 rx_err pulse", n_rxe - b_rxe, 1);
    chk("R4 no done on error", n_done - b_done, 0);

    // R7 ON in IDLE
    b_done = n_done;
    do_act(1);
    chk("R7 done only", n_done - b_done, 1);
    chk("R7 state", sess_state, 3);
    chk("R7 pins", {card_vcc_en, card_rst_n}, 3);

    // R8 warm reset, R6 answer start, R10 receive completion
    b_hold = hold_rises;
    do_act(3);
    chk("R8 warm state", sess_state, 1);
    chk("R8 vcc kept/rst low", {card_vcc_en, card_rst_n}, 2);
    wait_state(2);
    chk("R8 hold edges", hold_rises - b_hold, 400);
    idle_cycles(5);
    pulse_ev(0);
    chk("R6 atr to RX", sess_state, 4);
    b_done = n_done;
    pulse_ev(2);
    chk("R10 rx_done to IDLE", sess_state, 3);
    chk("R10 rx_done done", n_done - b_done, 1);

    // R12 events ignored in IDLE
    b_done = n_done; b_rxe = n_rxe; b_dme = n_dme;
    pulse_ev(3); pulse_ev(5); pulse_ev(1);
    chk("R12 idle state", sess_state, 3);
    chk("R12 idle irqs", (n_done - b_done) + (n_rxe - b_rxe) + (n_dme - b_dme), 0);

    // Randomized transfers: R2, R3, R9, R10
    for (int it = 0; it < 40; it++) begin
      int op, k;
      op = 4 + int'($urandom % 3);
      k  = int'($urandom % 4);
      do_act(op);
      chk("R10 enter transfer", sess_state, op);
      chk("R2 busy transfer", busy, exp_busy(op));
      if ($urandom % 2 == 1) begin
        b_serr = n_serr;
        do_act(1 + int'($urandom % 7));
        chk("R3 illegal in transfer", n_serr - b_serr, 1);
        chk("R3 transfer continues", sess_state, op);
      end
      b_done = n_done; b_rxe = n_rxe; b_rte = n_rte; b_dme = n_dme;
      if (k == 0) begin
        if (op == 6) begin
          pulse_ev(1);
          chk("R10 TX_RX to RX", sess_state, 4);
          chk("R10 no done mid", n_done - b_done, 0);
          pulse_ev(2);
        end else begin
          pulse_ev(op == 4 ? 2 : 1);
        end
        chk("R10 done pulse", n_done - b_done, 1);
      end else begin
        pulse_ev(2 + k);
        chk("R9 rx_err", n_rxe - b_rxe, k == 1 ? 1 : 0);
        chk("R9 retry_err", n_rte - b_rte, k == 2 ? 1 : 0);
        chk("R9 dma_err", n_dme - b_dme, k == 3 ? 1 : 0);
        chk("R9 no done", n_done - b_done, 0);
      end
      chk("R9 end state", sess_state, exp_end_state(op, k));
      chk("R2 busy idle", busy, exp_busy(3));
    end

    // R11 clock stop
    stop_level = 1'b1;
    b_done = n_done;
    do_act(7);
    chk("R11 stopping", sess_state, 7);
    wait_state(8);
    chk("R11 done on STOP", n_done - b_done, 1);
    idle_cycles(2);
    chk("R11 level high", card_clk, 1);
    chk("R2 busy STOP", busy, exp_busy(8));
    b_serr = n_serr;
    do_act(4);
    chk("R11 illegal in STOP", n_serr - b_serr, 1);
    chk("R11 stays STOP", sess_state, 8);
    stop_level = 1'b0;
    idle_cycles(2);
    chk("R11 level low", card_clk, 0);
    b_rxe = n_rxe;
    pulse_ev(3);
    chk("R12 STOP ignores error", n_rxe - b_rxe, 0);
    chk("R12 STOP state", sess_state, 8);
    b_done = n_done;
    do_act(1);
    chk("R11 resuming", sess_state, 9);
    wait_state(3);
    chk("R11 resume done", n_done - b_done, 1);

    // R13 deactivation
    b_done = n_done;
    do_act(2);
    chk("R13 rst low first", sess_state, 10);
    chk("R13 pins step1", {card_vcc_en, card_rst_n}, 2);
    wait_state(11);
    idle_cycles(1);
    chk("R13 clock stopped", card_clk, 0);
    chk("R13 vcc still on", card_vcc_en, 1);
    wait_state(0);
    chk("R13 vcc dropped", card_vcc_en, 0);
    chk("R4 done on OFF", n_done - b_done, 1);
    b_serr = n_serr;
    do_act(2);
    chk("R3 OFF in OFF", n_serr - b_serr, 1);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual 1 expected 0");
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule